// File: doc/BRIEF.md
# Accumulator ALU with Flags

A purely combinational arithmetic-logic unit for a small accumulator machine. The unit takes the current accumulator value, a parameter operand, a 5-bit operation code, the 3-bit parameter-mode field (used by the special opcode to pick a shift or rotate), and the current flag word. It returns the next accumulator value, a write-enable for the accumulator, the next flag word, and an illegal-operation indication. Register storage, instruction fetch and memory access stay outside the block.

The data path width is set by `WIDTH`, either 8 or 16. Add, subtract, add-with-carry, compare, XOR, AND, OR, a one-bit logical shift right, and a one-bit rotate right through carry all produce results and flags. A move-high operation places the low byte of the parameter into the upper byte of the accumulator, but only when `WIDTH` is 16. Subtraction is computed as A + ~P + 1, so a set carry means that no borrow occurred, and "less than" reads as carry clear.

For opcodes this unit does not handle, the accumulator is not written and the flags pass through unchanged. This lets the surrounding datapath apply `flags_o` on every instruction.

Top module: `acc_alu`

## Requirements
- R1: Opcode 00001 adds: `res_o` = (A+P) mod 2^WIDTH, `acc_we_o`=1, C = carry out of the top bit, V = 1 exactly when both operands share a sign bit that differs from the result's sign bit.
- R2: Opcode 00010 subtracts: `res_o` = (A-P) mod 2^WIDTH, computed as A + ~P + 1. C = carry out of that sum, so C=1 means A >= P unsigned. V is set on signed overflow of the subtraction. `acc_we_o`=1.
- R3: Opcode 00011 adds with carry: `res_o` = (A+P+C_in) mod 2^WIDTH, with C and V as for R1 on the three-term sum. `acc_we_o`=1.
- R4: Opcode 00111 compares: the flags and `res_o` are exactly those of R2, but `acc_we_o`=0.
- R5: Opcodes 00100 (XOR), 00101 (AND) and 00110 (OR) give the bitwise result with `acc_we_o`=1. V is cleared and C keeps its input value.
- R6: Every flag-updating operation (R1-R5, R7, R8) sets Z = (result == 0) and N = the result's top bit. The flag word is packed as {N,V,Z,C}, with bit 3 = N and bit 0 = C.
- R7: Opcode 00000 with mode 001 shifts right logically: `res_o` = {0, A[W-1:1]}, C = A[0], V cleared, `acc_we_o`=1.
- R8: Opcode 00000 with mode 010 rotates right through carry: `res_o` = {C_in, A[W-1:1]}, C = A[0], V held, `acc_we_o`=1.
- R9: With WIDTH=16, opcode 01011 gives `res_o` = {P[7:0], 8'h00} with `acc_we_o`=1 and the flags unchanged.
- R10: With WIDTH=8, opcode 01011 raises `illegal_o`. `acc_we_o` is 0 and the flags are unchanged.
- R11: Every other opcode, and opcode 00000 with any mode other than 001 or 010, gives `acc_we_o`=0, `illegal_o`=0, `flags_o`=`flags_i` and `res_o`=A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Current accumulator value |
| param_i | input | WIDTH | Parameter operand |
| op_i | input | 5 | Operation code |
| mode_i | input | 3 | Parameter-mode field; selects the shift/rotate under opcode 00000 |
| flags_i | input | 4 | Current flags {N,V,Z,C} |
| res_o | output | WIDTH | Next accumulator value |
| acc_we_o | output | 1 | Accumulator write-enable |
| flags_o | output | 4 | Next flags {N,V,Z,C} |
| illegal_o | output | 1 | Operation not legal at this width |

## Verification
The bench builds two copies side by side, one with WIDTH=8 and one with WIDTH=16, and drives both with the same stimulus. The 8-bit copy is needed to see move-high rejected and to reach the 8-bit carry and overflow boundaries with random operands. The 16-bit copy reaches the legal move-high path and checks that carry and sign are taken from bit 15 rather than bit 7.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam logic [4:0] OP_SPECIAL = 5'b00000;
  localparam logic [4:0] OP_ADD     = 5'b00001;
  localparam logic [4:0] OP_SUB     = 5'b00010;
  localparam logic [4:0] OP_ADC     = 5'b00011;
  localparam logic [4:0] OP_XOR     = 5'b00100;
  localparam logic [4:0] OP_AND     = 5'b00101;
  localparam logic [4:0] OP_OR      = 5'b00110;
  localparam logic [4:0] OP_CMP     = 5'b00111;
  localparam logic [4:0] OP_MOVHI   = 5'b01011;

  localparam logic [2:0] MODE_LSR = 3'b001;
  localparam logic [2:0] MODE_ROR = 3'b010;

  // logic unit select, equals op[1:0] of the logic opcodes
  typedef enum logic [1:0] {
    LOG_XOR = 2'b00,
    LOG_AND = 2'b01,
    LOG_OR  = 2'b10
  } log_fn_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      LOG_AND: res_o = a_i & b_i;
      LOG_OR:  res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  input  logic             rot_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  logic fill;

  assign fill   = rot_i & cin_i;
  assign res_o  = {fill, a_i[WIDTH-1:1]};
  assign cout_o = a_i[0];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] param_i,
  input  logic [4:0]       op_i,
  input  logic [2:0]       mode_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] res_o,
  output logic             acc_we_o,
  output logic [3:0]       flags_o,
  output logic             illegal_o
);
  localparam bit HAS_HIGH = (WIDTH > 8);

  alu_flags_t       fl_in, fl_nx;
  logic             is_sub, add_cin;
  logic [WIDTH-1:0] sum, log_res, sh_res, hi_res, res;
  logic             sum_c, sum_v, sh_c;
  logic             we, ill, upd;

  assign fl_in   = alu_flags_t'(flags_i);
  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign add_cin = is_sub | ((op_i == OP_ADC) & fl_in.c);

  acc_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i   (a_i),
    .b_i   (param_i),
    .sub_i (is_sub),
    .cin_i (add_cin),
    .sum_o (sum),
    .cout_o(sum_c),
    .ovf_o (sum_v)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (param_i),
    .fn_i (op_i[1:0]),
    .res_o(log_res)
  );

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i   (a_i),
    .cin_i (fl_in.c),
    .rot_i (mode_i == MODE_ROR),
    .res_o (sh_res),
    .cout_o(sh_c)
  );

  generate
    if (HAS_HIGH) begin : g_high
      assign hi_res = {param_i[WIDTH-9:0], 8'h00};
    end else begin : g_no_high
      assign hi_res = '0;
    end
  endgenerate

  always_comb begin
    res   = a_i;
    we    = 1'b0;
    ill   = 1'b0;
    upd   = 1'b0;
    fl_nx = fl_in;
    unique case (op_i)
      OP_ADD, OP_SUB, OP_ADC, OP_CMP: begin
        res     = sum;
        we      = (op_i != OP_CMP);
        fl_nx.c = sum_c;
        fl_nx.v = sum_v;
        upd     = 1'b1;
      end
      OP_XOR, OP_AND, OP_OR: begin
        res     = log_res;
        we      = 1'b1;
        fl_nx.v = 1'b0;
        upd     = 1'b1;
      end
      OP_SPECIAL: begin
        if (mode_i == MODE_LSR || mode_i == MODE_ROR) begin
          res     = sh_res;
          we      = 1'b1;
          fl_nx.c = sh_c;
          if (mode_i == MODE_LSR) fl_nx.v = 1'b0;
          upd     = 1'b1;
        end
      end
      OP_MOVHI: begin
        if (HAS_HIGH) begin
          res = hi_res;
          we  = 1'b1;
        end else begin
          ill = 1'b1;
        end
      end
      default: ;
    endcase
    if (upd) begin
      fl_nx.z = (res == '0);
      fl_nx.n = res[WIDTH-1];
    end
  end

  assign res_o     = res;
  assign acc_we_o  = we;
  assign flags_o   = fl_nx;
  assign illegal_o = ill;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] param_i,
  input logic [4:0]       op_i,
  input logic [2:0]       mode_i,
  input logic [3:0]       flags_i,
  input logic [WIDTH-1:0] res_o,
  input logic             acc_we_o,
  input logic [3:0]       flags_o,
  input logic             illegal_o
);
  logic arith_op, logic_op, shift_op, hi_op, flag_op;

  assign arith_op = (op_i >= 5'd1) && (op_i <= 5'd3);
  assign logic_op = (op_i >= 5'd4) && (op_i <= 5'd6);
  assign shift_op = (op_i == 5'd0) && (mode_i == 3'd1 || mode_i == 3'd2);
  assign hi_op    = (op_i == 5'd11);
  assign flag_op  = arith_op || logic_op || shift_op || (op_i == 5'd7);

  always_comb begin
    // R4
    cmp_no_write_chk: assert (!(op_i == 5'd7) || !acc_we_o);
    // R5
    logic_carry_hold_chk: assert (!logic_op || (flags_o[0] == flags_i[0] && !flags_o[2]));
    // R6
    zero_flag_chk: assert (!flag_op || (flags_o[1] == (res_o == '0)));
    // R6
    neg_flag_chk: assert (!flag_op || (flags_o[3] == res_o[WIDTH-1]));
    // R7
    lsr_fill_chk: assert (!(shift_op && mode_i == 3'd1) || (!res_o[WIDTH-1] && flags_o[0] == a_i[0]));
    // R8
    ror_fill_chk: assert (!(shift_op && mode_i == 3'd2) || (res_o[WIDTH-1] == flags_i[0] && flags_o[0] == a_i[0]));
    // R10
    illegal_quiet_chk: assert (!illegal_o || (!acc_we_o && flags_o == flags_i && hi_op));
    // R11
    flags_hold_chk: assert (flag_op || flags_o == flags_i);
    // R11
    no_write_chk: assert (flag_op || hi_op || (!acc_we_o && res_o == a_i));
  end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .param_i  (param_i),
  .op_i     (op_i),
  .mode_i   (mode_i),
  .flags_i  (flags_i),
  .res_o    (res_o),
  .acc_we_o (acc_we_o),
  .flags_o  (flags_o),
  .illegal_o(illegal_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a, p;
  logic [4:0]  op;
  logic [2:0]  mode;
  logic [3:0]  fl;

  logic [7:0]  r8;
  logic [15:0] r16;
  logic        we8, we16, ill8, ill16;
  logic [3:0]  f8, f16;

  int total = 0;
  int bad = 0;
  bit done = 0;

  acc_alu #(.WIDTH(8)) u_acc_alu (
    .a_i(a[7:0]), .param_i(p[7:0]), .op_i(op), .mode_i(mode), .flags_i(fl),
    .res_o(r8), .acc_we_o(we8), .flags_o(f8), .illegal_o(ill8)
  );

  acc_alu #(.WIDTH(16)) u_acc_alu_w16 (
    .a_i(a), .param_i(p), .op_i(op), .mode_i(mode), .flags_i(fl),
    .res_o(r16), .acc_we_o(we16), .flags_o(f16), .illegal_o(ill16)
  );

  // reference model; flags packed {N,V,Z,C}
  function automatic void model(input int w, input logic [15:0] ai, input logic [15:0] pi,
                                input logic [4:0] o, input logic [2:0] m, input logic [3:0] fi,
                                output logic [15:0] res, output logic we,
                                output logic [3:0] fo, output logic ill);
    logic [16:0] mask, t, av, pv, bv;
    logic c, v, upd, msb;
    mask = (17'd1 << w) - 17'd1;
    av = {1'b0, ai} & mask;
    pv = {1'b0, pi} & mask;
    res = ai & mask[15:0];
    we = 0; ill = 0; fo = fi; upd = 0;
    c = fi[0]; v = fi[2];
    case (o)
      5'd1, 5'd2, 5'd3, 5'd7: begin
        bv = (o == 5'd2 || o == 5'd7) ? (~pv & mask) : pv;
        t = av + bv + ((o == 5'd2 || o == 5'd7) ? 17'd1 : (o == 5'd3 ? {16'd0, fi[0]} : 17'd0));
        res = t[15:0] & mask[15:0];
        c = t[w];
        msb = t[w-1];
        v = (av[w-1] == bv[w-1]) && (msb != av[w-1]);
        we = (o != 5'd7); upd = 1;
      end
      5'd4: begin res = (ai ^ pi) & mask[15:0]; v = 0; we = 1; upd = 1; end
      5'd5: begin res = (ai & pi) & mask[15:0]; v = 0; we = 1; upd = 1; end
      5'd6: begin res = (ai | pi) & mask[15:0]; v = 0; we = 1; upd = 1; end
      5'd0: begin
        if (m == 3'd1 || m == 3'd2) begin
          res = av[15:0] >> 1;
          if (m == 3'd2 && fi[0]) res = res | (16'd1 << (w - 1));
          else if (m == 3'd1) v = 0;
          c = ai[0]; we = 1; upd = 1;
        end
      end
      5'd11: begin
        if (w == 16) begin res = {pi[7:0], 8'h00}; we = 1; end
        else ill = 1;
      end
      default: ;
    endcase
    if (upd) fo = {res[w-1], v, (res == 16'd0), c};
  endfunction

  function automatic string tag_of(input logic [4:0] o, input logic [2:0] m);
    case (o)
      5'd1: return "R1";
      5'd2: return "R2";
      5'd3: return "R3";
      5'd7: return "R4";
      5'd4, 5'd5, 5'd6: return "R5";
      5'd0: return (m == 3'd1) ? "R7" : (m == 3'd2) ? "R8" : "R11";
      5'd11: return "R9/R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_one(input string tag, input int w, input logic [15:0] got_r,
                           input logic got_we, input logic [3:0] got_f, input logic got_ill);
    logic [15:0] er; logic ew, ei; logic [3:0] ef;
    model(w, a, p, op, mode, fl, er, ew, ef, ei);
    total++;
    if (got_r !== er || got_we !== ew || got_f !== ef || got_ill !== ei) begin
      bad++;
      $display("FAIL %s w=%0d op=%b mode=%b a=%h p=%h fl=%b: got res=%h we=%b fl=%b ill=%b exp res=%h we=%b fl=%b ill=%b",
               tag, w, op, mode, a, p, fl, got_r, got_we, got_f, got_ill, er, ew, ef, ei);
    end
  endtask

  task automatic apply(input string tag, input logic [4:0] o, input logic [2:0] m,
                       input logic [15:0] av, input logic [15:0] pv, input logic [3:0] f);
    @(posedge clk);
    op = o; mode = m; a = av; p = pv; fl = f;
    @(negedge clk);
    check_one(tag, 8, {8'h00, r8}, we8, f8, ill8);
    check_one(tag, 16, r16, we16, f16, ill16);
  endtask

  initial begin
    a = '0; p = '0; op = 5'd0; mode = 3'd0; fl = 4'b0000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state / idle: NOP passes through (R11)
    apply("R11", 5'd0, 3'd0, 16'h1234, 16'h0, 4'b1010);
    apply("R1",  5'd1, 3'd4, 16'h007F, 16'h0001, 4'b0000);
    apply("R1",  5'd1, 3'd4, 16'hFFFF, 16'h0001, 4'b0000);
    apply("R1",  5'd1, 3'd4, 16'h7FFF, 16'h0001, 4'b0000);
    apply("R2",  5'd2, 3'd1, 16'h0005, 16'h0005, 4'b0000);
    apply("R2",  5'd2, 3'd1, 16'h0003, 16'h0005, 4'b0001);
    apply("R2",  5'd2, 3'd1, 16'h8000, 16'h0001, 4'b0000);
    apply("R3",  5'd3, 3'd3, 16'h00FF, 16'h0000, 4'b0001);
    apply("R3",  5'd3, 3'd3, 16'h0010, 16'h0010, 4'b0001);
    apply("R4",  5'd7, 3'd4, 16'h0042, 16'h0042, 4'b0000);
    apply("R4",  5'd7, 3'd4, 16'h0001, 16'h0002, 4'b0000);
    apply("R5",  5'd5, 3'd4, 16'h00F0, 16'h000F, 4'b0101);
    apply("R5",  5'd4, 3'd4, 16'hAAAA, 16'h5555, 4'b0100);
    apply("R5",  5'd6, 3'd4, 16'h0000, 16'h0000, 4'b0001);
    apply("R7",  5'd0, 3'd1, 16'h0001, 16'h0000, 4'b0100);
    apply("R7",  5'd0, 3'd1, 16'h8081, 16'h0000, 4'b0000);
    apply("R8",  5'd0, 3'd2, 16'h0002, 16'h0000, 4'b0101);
    apply("R8",  5'd0, 3'd2, 16'h0001, 16'h0000, 4'b0000);
    apply("R9/R10", 5'd11, 3'd4, 16'h1234, 16'h00AB, 4'b1111);
    apply("R11", 5'd19, 3'd4, 16'h5555, 16'h1234, 4'b0110);
    apply("R11", 5'd0, 3'd5, 16'h5555, 16'h1234, 4'b1001);
    apply("R11", 5'd10, 3'd3, 16'h0F0F, 16'hFFFF, 4'b0011);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] o;
      logic [2:0] m;
      o = (i % 3 == 0) ? 5'($urandom_range(31)) : 5'($urandom_range(7));
      if (i % 17 == 0) o = 5'd11;
      m = 3'($urandom_range(7));
      apply(tag_of(o, m), o, m, 16'($urandom), 16'($urandom), 4'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule